// File: doc/BRIEF.md
# DMA Write Request Executor

This block takes posted DMA write requests from an upstream I/O link and turns each one into memory-bus transactions. Each request arrives as a header beat followed by 64-bit data beats. An unmasked request carries a full 64-byte line and becomes a single bus write. A masked request carries per-byte enables. It becomes an atomic sequence: a locked read of the line, a byte-wise merge of the request data into the returned line, and a write that releases the lock.

The requester never receives a reply. The block handles one request at a time and stalls the link while that request is being executed. The bus side is a plain request/grant/done handshake. Requests use a one-hot vector indexed by a static 4-bit node number. A separate high-priority line is used only for the write-back of a masked request on node 8. Link parity errors, sequence errors and failed bus writes are recorded in an error log, which raises an interrupt until software clears it.

Top module: `dma_write_exec`

## Requirements
- R1: An unmasked request with eight good data beats produces exactly one bus command, a write (`bus_cmd`=1). It carries the header address and the eight beats as the line, with beat k in bits 64k+63..64k. No read is issued for it.
- R2: A masked request produces a locked read (`bus_cmd`=2) followed by an unlocking write (`bus_cmd`=3), both to the header address, and no other command.
- R3: Byte j of the unlocking-write line is request byte j when mask bit j is set and j/8 is below the length code; otherwise it is byte j of the read data. Mask bits in beats at or beyond the length code have no effect.
- R4: Plain writes and locked reads raise only `bus_req[node_id]`. The unlocking write raises `bus_req_hi` (with `bus_req` all zero) when `node_id` is 8 (4'b1000), and `bus_req[node_id]` otherwise.
- R5: A request line stays raised and unchanged until `bus_gnt` arrives. `bus_cmd` is non-zero only in a cycle where `bus_gnt` is high.
- R6: `in_ready` falls in the cycle after the last data beat is accepted. It stays low until the cycle after `bus_done` for the final write, or for the unlocking write.
- R7: Each data beat carries `in_par` equal to the XOR of its 64 data bits. A mismatch on any beat logs error type 1 with the header address, and the request is dropped without any bus request.
- R8: The expected beat count is 8 for an unmasked request and the length code for a masked one. A masked length code of 0 or above 8 never matches. When the received count differs from the expected count, error type 2 is logged and the request is dropped. A parity error takes precedence.
- R9: `bus_ok` low together with `bus_done` for a write or unlocking write logs error type 3 with the target address.
- R10: The log keeps the type and address of the first error. Any later error sets `err_ovf` instead. `err_clr` empties the log, clears the overflow bit and lowers `irq`.
- R11: `irq` is high exactly while the log holds an error.
- R12: After reset, `in_ready` is 1, no request line is raised, `bus_cmd` is 0 and the log is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 4 | Static node number of this port |
| in_valid | input | 1 | Link beat valid |
| in_ready | output | 1 | Link beat accept |
| in_first | input | 1 | Beat is a header (no data) |
| in_last | input | 1 | Beat is the final data beat |
| in_masked | input | 1 | Header: request is masked |
| in_len | input | 4 | Header: length code in data beats |
| in_addr | input | 32 | Header: target line address |
| in_mask | input | 64 | Header: per-byte enables |
| in_data | input | 64 | Data beat payload |
| in_par | input | 1 | Parity bit of the data beat |
| bus_req | output | 16 | One-hot normal request lines |
| bus_req_hi | output | 1 | Highest-priority request line |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 2 | Command in the grant cycle (0 none, 1 write, 2 locked read, 3 unlocking write) |
| bus_addr | output | 32 | Command address |
| bus_wdata | output | 512 | Write line |
| bus_done | input | 1 | Transaction completion pulse |
| bus_ok | input | 1 | Write success, qualified by bus_done |
| bus_rdata | input | 512 | Read line, qualified by bus_done |
| err_clr | input | 1 | Clear the error log |
| err_valid | output | 1 | Log holds an error |
| err_type | output | 2 | First error type (1 parity, 2 sequence, 3 write fail) |
| err_addr | output | 32 | Address of the first error |
| err_ovf | output | 1 | More errors followed the first |
| irq | output | 1 | Error interrupt |

## Verification
The hardest case to reach is the write-back of a masked request. It only appears after a locked read has been granted and completed, and only then does the choice between `bus_req_hi` and `bus_req[node_id]` become visible. The bench acts as the bus itself. It holds the grant back for several cycles to watch the request line stay put, grants and captures the command, then returns a known line with `bus_done`. This is repeated for node 3 and for node 8. Mask bits placed beyond the length code show whether they are ignored in the merged line.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_WRITE  = 2'd1,
        CMD_RDLOCK = 2'd2,
        CMD_WRUNLK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_PARITY = 2'd1,
        ERR_SEQ    = 2'd2,
        ERR_WRFAIL = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        S_RX, S_DECIDE, S_ARB_WR, S_WAIT_WR, S_ARB_RD, S_WAIT_RD, S_ARB_WB
    } exec_state_e;

    function automatic logic beat_parity(input logic [63:0] d);
        return ^d;
    endfunction

endpackage

// File: rtl/dmaw_rx.sv
module dmaw_rx
    import dmaw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_W     = 64,
    parameter int LINE_BEATS = 8,
    parameter int LEN_W      = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic                              in_ready,
    input  logic                              in_first,
    input  logic                              in_last,
    input  logic                              in_masked,
    input  logic [LEN_W-1:0]                  in_len,
    input  logic [ADDR_W-1:0]                 in_addr,
    input  logic [BEAT_W*LINE_BEATS/8-1:0]    in_mask,
    input  logic [BEAT_W-1:0]                 in_data,
    input  logic                              in_par,
    output logic                              last_acc,
    output logic                              rq_masked,
    output logic [ADDR_W-1:0]                 rq_addr,
    output logic [BEAT_W*LINE_BEATS/8-1:0]    rq_mask,
    output logic [BEAT_W*LINE_BEATS-1:0]      rq_line,
    output err_e                              rq_err
);
    localparam int BPB    = BEAT_W / 8;
    localparam int IDX_W  = $clog2(LINE_BEATS);
    localparam int CNT_W  = LEN_W;
    localparam int LBYTES = BPB * LINE_BEATS;

    logic                  active;
    logic [CNT_W-1:0]      cnt;
    logic                  par_bad;
    logic [LEN_W-1:0]      hdr_len;
    logic [LBYTES-1:0]     hdr_mask;
    logic [BEAT_W-1:0]     beats [LINE_BEATS];

    logic take, hdr_take, beat_take, beat_bad;
    logic [CNT_W-1:0] got, expect_cnt;
    logic len_bad;

    assign take      = in_valid && in_ready;
    assign hdr_take  = take && in_first;
    assign beat_take = take && !in_first && active;
    assign last_acc  = beat_take && in_last;
    assign beat_bad  = beat_parity(in_data) != in_par;

    always_comb begin
        got        = (cnt == '1) ? cnt : cnt + CNT_W'(1);
        expect_cnt = rq_masked ? hdr_len : CNT_W'(LINE_BEATS);
        len_bad    = rq_masked && (hdr_len == '0 || hdr_len > LEN_W'(LINE_BEATS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            par_bad   <= 1'b0;
            hdr_len   <= '0;
            hdr_mask  <= '0;
            rq_masked <= 1'b0;
            rq_addr   <= '0;
            rq_err    <= ERR_NONE;
        end else if (hdr_take) begin
            active    <= 1'b1;
            cnt       <= '0;
            par_bad   <= 1'b0;
            hdr_len   <= in_len;
            hdr_mask  <= in_mask;
            rq_masked <= in_masked;
            rq_addr   <= in_addr;
        end else if (beat_take) begin
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
            if (beat_bad) par_bad <= 1'b1;
            if (in_last) begin
                active <= 1'b0;
                if (par_bad || beat_bad)
                    rq_err <= ERR_PARITY;
                else if (len_bad || got != expect_cnt)
                    rq_err <= ERR_SEQ;
                else
                    rq_err <= ERR_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (beat_take && cnt < CNT_W'(LINE_BEATS))
            beats[cnt[IDX_W-1:0]] <= in_data;
    end

    for (genvar b = 0; b < LINE_BEATS; b++) begin : g_beat
        assign rq_line[b*BEAT_W +: BEAT_W] = beats[b];
        assign rq_mask[b*BPB +: BPB] = rq_masked
            ? (hdr_mask[b*BPB +: BPB] & {BPB{LEN_W'(b) < hdr_len}})
            : {BPB{1'b1}};
    end

    // R8: a counted beat is never lost before the final beat is taken
    p_cnt_moves_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_take && !in_last && cnt != '1) |=> cnt == $past(cnt) + CNT_W'(1));

endmodule

// File: rtl/dmaw_merge.sv
module dmaw_merge #(
    parameter int LINE_W = 512
) (
    input  logic [LINE_W-1:0]   new_line,
    input  logic [LINE_W-1:0]   old_line,
    input  logic [LINE_W/8-1:0] byte_en,
    output logic [LINE_W-1:0]   merged
);
    for (genvar i = 0; i < LINE_W/8; i++) begin : g_byte
        assign merged[i*8 +: 8] = byte_en[i] ? new_line[i*8 +: 8] : old_line[i*8 +: 8];
    end
endmodule

// File: rtl/dmaw_arb_sel.sv
module dmaw_arb_sel #(
    parameter int NODE_W  = 4,
    parameter int HI_NODE = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NODE_W-1:0]    node_id,
    input  logic                 want,
    input  logic                 writeback,
    output logic [2**NODE_W-1:0] bus_req,
    output logic                 bus_req_hi
);
    localparam int NREQ = 2**NODE_W;

    logic use_hi;
    assign use_hi     = writeback && (node_id == NODE_W'(HI_NODE));
    assign bus_req_hi = want && use_hi;

    for (genvar n = 0; n < NREQ; n++) begin : g_line
        assign bus_req[n] = want && !use_hi && (node_id == NODE_W'(n));
    end

    p_req_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_req));
    p_req_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !((|bus_req) && bus_req_hi));
    p_hi_node_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req_hi |-> node_id == NODE_W'(HI_NODE));

endmodule

// File: rtl/dmaw_errlog.sv
module dmaw_errlog
    import dmaw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  err_e              ev_type,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              clr,
    output logic              err_valid,
    output err_e              err_type,
    output logic [ADDR_W-1:0] err_addr,
    output logic              err_ovf,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            err_valid <= 1'b0;
            err_type  <= ERR_NONE;
            err_addr  <= '0;
            err_ovf   <= 1'b0;
        end else begin
            if (clr) begin
                err_valid <= 1'b0;
                err_type  <= ERR_NONE;
                err_addr  <= '0;
                err_ovf   <= 1'b0;
            end
            if (ev_valid) begin
                if (!err_valid || clr) begin
                    err_valid <= 1'b1;
                    err_type  <= ev_type;
                    err_addr  <= ev_addr;
                end else begin
                    err_ovf <= 1'b1;
                end
            end
        end
    end

    assign irq = err_valid;

    p_first_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !clr) |=> err_valid && $stable(err_type) && $stable(err_addr));
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !ev_valid) |=> !irq && !err_ovf);
    p_ovf_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_ovf) |-> $past(err_valid && ev_valid));

endmodule

// File: rtl/dma_write_exec.sv
module dma_write_exec
    import dmaw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_W     = 64,
    parameter int LINE_BEATS = 8,
    parameter int LEN_W      = 4,
    parameter int NODE_W     = 4,
    parameter int HI_NODE    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NODE_W-1:0]              node_id,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic                           in_first,
    input  logic                           in_last,
    input  logic                           in_masked,
    input  logic [LEN_W-1:0]               in_len,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic [BEAT_W*LINE_BEATS/8-1:0] in_mask,
    input  logic [BEAT_W-1:0]              in_data,
    input  logic                           in_par,
    output logic [2**NODE_W-1:0]           bus_req,
    output logic                           bus_req_hi,
    input  logic                           bus_gnt,
    output logic [1:0]                     bus_cmd,
    output logic [ADDR_W-1:0]              bus_addr,
    output logic [BEAT_W*LINE_BEATS-1:0]   bus_wdata,
    input  logic                           bus_done,
    input  logic                           bus_ok,
    input  logic [BEAT_W*LINE_BEATS-1:0]   bus_rdata,
    input  logic                           err_clr,
    output logic                           err_valid,
    output logic [1:0]                     err_type,
    output logic [ADDR_W-1:0]              err_addr,
    output logic                           err_ovf,
    output logic                           irq
);
    localparam int LINE_W = BEAT_W * LINE_BEATS;
    localparam int LBYTES = LINE_W / 8;

    exec_state_e state;
    logic                last_acc, rq_masked;
    logic [ADDR_W-1:0]   rq_addr;
    logic [LBYTES-1:0]   rq_mask;
    logic [LINE_W-1:0]   rq_line, merged, wb_line;
    err_e                rq_err;
    logic                want, fire, lock_held;
    bus_cmd_e            cmd;
    logic                ev_valid;
    err_e                ev_type, log_type;

    assign in_ready = (state == S_RX);

    dmaw_rx #(
        .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LINE_BEATS(LINE_BEATS), .LEN_W(LEN_W)
    ) u_rx (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_masked(in_masked),
        .in_len(in_len), .in_addr(in_addr), .in_mask(in_mask),
        .in_data(in_data), .in_par(in_par), .last_acc(last_acc),
        .rq_masked(rq_masked), .rq_addr(rq_addr), .rq_mask(rq_mask),
        .rq_line(rq_line), .rq_err(rq_err)
    );

    dmaw_merge #(.LINE_W(LINE_W)) u_merge (
        .new_line(rq_line), .old_line(bus_rdata), .byte_en(rq_mask), .merged(merged)
    );

    assign want = (state == S_ARB_WR) || (state == S_ARB_RD) || (state == S_ARB_WB);
    assign fire = want && bus_gnt;

    dmaw_arb_sel #(.NODE_W(NODE_W), .HI_NODE(HI_NODE)) u_arb (
        .clk(clk), .rst(rst), .node_id(node_id), .want(want),
        .writeback(state == S_ARB_WB), .bus_req(bus_req), .bus_req_hi(bus_req_hi)
    );

    always_comb begin
        cmd = CMD_NONE;
        if (fire) begin
            case (state)
                S_ARB_WR: cmd = CMD_WRITE;
                S_ARB_RD: cmd = CMD_RDLOCK;
                S_ARB_WB: cmd = CMD_WRUNLK;
                default:  cmd = CMD_NONE;
            endcase
        end
    end

    assign bus_cmd   = cmd;
    assign bus_addr  = fire ? rq_addr : '0;
    assign bus_wdata = !fire ? '0 : (state == S_ARB_WB) ? wb_line : rq_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_RX;
            wb_line   <= '0;
            lock_held <= 1'b0;
        end else begin
            case (state)
                S_RX:      if (last_acc) state <= S_DECIDE;
                S_DECIDE: begin
                    if (rq_err != ERR_NONE) state <= S_RX;
                    else if (rq_masked)     state <= S_ARB_RD;
                    else                    state <= S_ARB_WR;
                end
                S_ARB_WR:  if (bus_gnt) state <= S_WAIT_WR;
                S_ARB_RD: begin
                    if (bus_gnt) begin
                        state     <= S_WAIT_RD;
                        lock_held <= 1'b1;
                    end
                end
                S_WAIT_RD: begin
                    if (bus_done) begin
                        wb_line <= merged;
                        state   <= S_ARB_WB;
                    end
                end
                S_ARB_WB:  if (bus_gnt) state <= S_WAIT_WR;
                S_WAIT_WR: begin
                    if (bus_done) begin
                        state     <= S_RX;
                        lock_held <= 1'b0;
                    end
                end
                default:   state <= S_RX;
            endcase
        end
    end

    always_comb begin
        ev_valid = 1'b0;
        ev_type  = ERR_NONE;
        if (state == S_DECIDE && rq_err != ERR_NONE) begin
            ev_valid = 1'b1;
            ev_type  = rq_err;
        end else if (state == S_WAIT_WR && bus_done && !bus_ok) begin
            ev_valid = 1'b1;
            ev_type  = ERR_WRFAIL;
        end
    end

    dmaw_errlog #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_type(ev_type),
        .ev_addr(rq_addr), .clr(err_clr), .err_valid(err_valid),
        .err_type(log_type), .err_addr(err_addr), .err_ovf(err_ovf), .irq(irq)
    );
    assign err_type = log_type;

    p_unm_no_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == CMD_RDLOCK) |-> rq_masked);
    p_lock_first_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == CMD_WRUNLK) |-> lock_held);
    p_cmd_gnt_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd != CMD_NONE) |-> bus_gnt && ((|bus_req) || bus_req_hi));
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (((|bus_req) || bus_req_hi) && !bus_gnt) |=> $stable(bus_req) && $stable(bus_req_hi));
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
        last_acc |=> !in_ready);
    p_ready_back_r6: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT_WR && bus_done) |=> in_ready);
    p_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECIDE && rq_err != ERR_NONE) |=> !(|bus_req) && !bus_req_hi && in_ready);

endmodule

// File: tb/dma_write_exec_test.sv
module dma_write_exec_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst;
    logic [3:0]   node_id;
    logic         in_valid, in_ready, in_first, in_last, in_masked, in_par;
    logic [3:0]   in_len;
    logic [31:0]  in_addr;
    logic [63:0]  in_mask, in_data;
    logic [15:0]  bus_req;
    logic         bus_req_hi, bus_gnt, bus_done, bus_ok;
    logic [1:0]   bus_cmd;
    logic [31:0]  bus_addr;
    logic [511:0] bus_wdata, bus_rdata;
    logic         err_clr, err_valid, err_ovf, irq;
    logic [1:0]   err_type;
    logic [31:0]  err_addr;

    int checks = 0;
    int failures = 0;

    dma_write_exec uut (
        .clk(clk), .rst(rst), .node_id(node_id), .in_valid(in_valid), .in_ready(in_ready),
        .in_first(in_first), .in_last(in_last), .in_masked(in_masked), .in_len(in_len),
        .in_addr(in_addr), .in_mask(in_mask), .in_data(in_data), .in_par(in_par),
        .bus_req(bus_req), .bus_req_hi(bus_req_hi), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ok(bus_ok),
        .bus_rdata(bus_rdata), .err_clr(err_clr), .err_valid(err_valid), .err_type(err_type),
        .err_addr(err_addr), .err_ovf(err_ovf), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_beat(input int seed, input int i);
        return {32'(seed * 977 + i * 31 + 7), 32'(seed * 13 ^ (i << 9) ^ 32'h5a5a1234)};
    endfunction

    logic [511:0] sent_line;

    task automatic send_pkt(input bit masked, input logic [3:0] len, input logic [31:0] addr,
                            input logic [63:0] mask, input int nbeats, input int seed, input int bad);
        sent_line = '0;
        @(negedge clk);
        in_valid = 1; in_first = 1; in_last = 0; in_masked = masked; in_len = len;
        in_addr = addr; in_mask = mask; in_data = '0; in_par = 0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < nbeats; i++) begin
            in_first = 0;
            in_last  = (i == nbeats - 1);
            in_data  = mk_beat(seed, i);
            in_par   = (^in_data) ^ (i == bad);
            if (i < 8) sent_line[i*64 +: 64] = in_data;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
    endtask

    logic [1:0]   s_cmd;
    logic [31:0]  s_addr;
    logic [511:0] s_data;
    logic [15:0]  s_req;
    logic         s_hi;

    task automatic serve(input bit ok, input logic [511:0] rd);
        int t = 0;
        while (bus_req == '0 && !bus_req_hi && t < 100) begin @(negedge clk); t++; end
        chk(t < 100, "R5 request seen", 512'(t), 512'(0));
        s_req = bus_req; s_hi = bus_req_hi;
        repeat (3) @(negedge clk);
        chk(bus_req == s_req && bus_req_hi == s_hi, "R5 request held before grant",
            512'({bus_req_hi, bus_req}), 512'({s_hi, s_req}));
        chk(bus_cmd == 2'd0, "R5 no command without grant", 512'(bus_cmd), 512'(0));
        bus_gnt = 1;
        #1;
        s_cmd = bus_cmd; s_addr = bus_addr; s_data = bus_wdata;
        @(negedge clk);
        bus_gnt = 0;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b0, "R6 link stalled while busy", 512'(in_ready), 512'(0));
        bus_done = 1; bus_ok = ok; bus_rdata = rd;
        @(negedge clk);
        bus_done = 0; bus_ok = 0; bus_rdata = '0;
    endtask

    task automatic quiet(input int n, input string req);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_req != '0 || bus_req_hi) seen = 1;
        end
        chk(!seen, req, 512'(seen), 512'(0));
    endtask

    task automatic clear_log();
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        chk(!irq && !err_valid && !err_ovf, "R10 clear empties log",
            512'({irq, err_valid, err_ovf}), 512'(0));
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R12 ready after reset", 512'(in_ready), 512'(1));
        chk(bus_req == '0 && !bus_req_hi && bus_cmd == 2'd0, "R12 bus idle after reset",
            512'({bus_req_hi, bus_req, bus_cmd}), 512'(0));
        chk(!err_valid && !irq && !err_ovf, "R12 log empty after reset",
            512'({err_valid, irq, err_ovf}), 512'(0));
    endtask

    task automatic t_unmasked();
        node_id = 4'd3;
        send_pkt(0, 4'd8, 32'h0000_1240, '0, 8, 11, -1);
        chk(in_ready == 1'b0, "R6 ready drops after last beat", 512'(in_ready), 512'(0));
        serve(1, '0);
        chk(s_req == 16'h0008 && !s_hi, "R4 plain write on node line", 512'({s_hi, s_req}), 512'h0008);
        chk(s_cmd == 2'd1, "R1 single write command", 512'(s_cmd), 512'(1));
        chk(s_addr == 32'h0000_1240, "R1 write address", 512'(s_addr), 512'h1240);
        chk(s_data == sent_line, "R1 write line", s_data, sent_line);
        chk(in_ready == 1'b1, "R6 ready returns after done", 512'(in_ready), 512'(1));
        quiet(8, "R1 no further command");
        chk(!irq, "R11 no interrupt on success", 512'(irq), 512'(0));
    endtask

    task automatic t_masked(input logic [3:0] node, input logic [3:0] len, input logic [63:0] mask, input int seed);
        logic [511:0] mem, exp;
        mem = {8{64'hdead_beef_0bad_f00d ^ 64'(seed)}};
        node_id = node;
        send_pkt(1, len, 32'h0008_0c00 + 32'(seed), mask, int'(len), seed, -1);
        serve(1, mem);
        chk(s_cmd == 2'd2, "R2 locked read first", 512'(s_cmd), 512'(2));
        chk(s_addr == 32'h0008_0c00 + 32'(seed), "R2 read address", 512'(s_addr), 512'(32'h0008_0c00 + 32'(seed)));
        chk(s_req == (16'h1 << node) && !s_hi, "R4 locked read on node line",
            512'({s_hi, s_req}), 512'(16'h1 << node));
        serve(1, '0);
        chk(s_cmd == 2'd3, "R2 unlocking write second", 512'(s_cmd), 512'(3));
        chk(s_addr == 32'h0008_0c00 + 32'(seed), "R2 write-back address", 512'(s_addr), 512'(32'h0008_0c00 + 32'(seed)));
        if (node == 4'd8)
            chk(s_hi && s_req == '0, "R4 node 8 write-back on high line", 512'({s_hi, s_req}), 512'({1'b1, 16'h0}));
        else
            chk(!s_hi && s_req == (16'h1 << node), "R4 write-back on node line",
                512'({s_hi, s_req}), 512'(16'h1 << node));
        for (int j = 0; j < 64; j++)
            exp[j*8 +: 8] = (mask[j] && (j / 8) < int'(len)) ? sent_line[j*8 +: 8] : mem[j*8 +: 8];
        chk(s_data == exp, "R3 merged line", s_data, exp);
        quiet(6, "R2 no third command");
    endtask

    task automatic t_errors();
        node_id = 4'd5;
        send_pkt(0, 4'd8, 32'h0000_a000, '0, 8, 21, 3);
        quiet(6, "R7 parity request dropped");
        chk(err_valid && err_type == 2'd1 && err_addr == 32'h0000_a000, "R7 parity logged",
            512'({err_valid, err_type, err_addr}), 512'({1'b1, 2'd1, 32'h0000_a000}));
        chk(irq == 1'b1, "R11 interrupt raised", 512'(irq), 512'(1));
        send_pkt(1, 4'd3, 32'h0000_b000, 64'hff, 2, 22, -1);
        quiet(6, "R8 short masked request dropped");
        chk(err_ovf && err_type == 2'd1 && err_addr == 32'h0000_a000, "R10 first error kept, overflow set",
            512'({err_ovf, err_type, err_addr}), 512'({1'b1, 2'd1, 32'h0000_a000}));
        clear_log();
        send_pkt(0, 4'd8, 32'h0000_c000, '0, 7, 23, -1);
        quiet(6, "R8 short unmasked request dropped");
        chk(err_valid && err_type == 2'd2 && err_addr == 32'h0000_c000 && !err_ovf, "R8 sequence logged",
            512'({err_valid, err_type, err_addr}), 512'({1'b1, 2'd2, 32'h0000_c000}));
        clear_log();
        send_pkt(1, 4'd0, 32'h0000_c100, 64'hff, 1, 24, -1);
        quiet(6, "R8 zero length request dropped");
        chk(err_valid && err_type == 2'd2, "R8 zero length code logged", 512'(err_type), 512'(2));
        clear_log();
    endtask

    task automatic t_wrfail();
        node_id = 4'd1;
        send_pkt(0, 4'd8, 32'h0000_d040, '0, 8, 31, -1);
        serve(0, '0);
        @(negedge clk);
        chk(err_valid && err_type == 2'd3 && err_addr == 32'h0000_d040, "R9 write failure logged",
            512'({err_valid, err_type, err_addr}), 512'({1'b1, 2'd3, 32'h0000_d040}));
        chk(irq == 1'b1, "R11 interrupt on write failure", 512'(irq), 512'(1));
        clear_log();
    endtask

    bit timed_out = 0;

    initial begin
        rst = 1; node_id = 0; in_valid = 0; in_first = 0; in_last = 0; in_masked = 0;
        in_len = 0; in_addr = 0; in_mask = 0; in_data = 0; in_par = 0;
        bus_gnt = 0; bus_done = 0; bus_ok = 0; bus_rdata = '0; err_clr = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_unmasked();
                t_masked(4'd3, 4'd2, 64'h0000_0100_0000_c3a5, 41);
                t_masked(4'd8, 4'd5, 64'h8000_00f0_0f00_ff01, 42);
                t_masked(4'd8, 4'd8, 64'hffff_ffff_ffff_ffff, 43);
                t_errors();
                t_wrfail();
            end
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(0, "watchdog expired", 512'(1), 512'(0));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule